// File: doc/BRIEF.md
# Accumulator Field Extract Unit

This unit turns a 64-bit accumulator into a 32-bit result. It works in one of two modes. Shift mode applies an arithmetic right shift to the accumulator. That shift can round to nearest and can clamp the outcome to the signed 32-bit range. Position mode reads a bit position from the control word and returns the field of `amount+1` bits whose top bit is at that position. The unit can then step the position down past the field it consumed, so a stream of fields can be read from the same accumulator in successive requests.

The caller presents the accumulator, the current control word and the operation on one cycle with `reqValid` high. One cycle later the unit returns the result, the updated control word and `respValid`. The caller writes the control word back wherever it is kept. The accumulator itself is never written.

Top module: `acc_extract_unit`

## Requirements
- R1: While `rstN` is low, and after it has been low, `respValid`, `result` and `ctlOut` are all zero until the first request.
- R2: A request sampled at a rising edge with `reqValid` high makes `respValid` high after that edge, with `result` and `ctlOut` updated in the same cycle. With `reqValid` low, `respValid` goes low and `result` and `ctlOut` keep their values.
- R3: Shift mode (`fieldMode`=0) returns the low 32 bits of the accumulator arithmetically shifted right by `amount` (0 to 31). An `amount` of 0 passes the accumulator through.
- R4: With `roundEn` and a nonzero `amount`, 2^(amount-1) is added to the accumulator before the shift. With `amount` 0, rounding has no effect.
- R5: If a non-negative accumulator turns negative through the rounding addition, the overflow flag (control bit 23) is set. With `satEn` the value that is shifted is then the largest positive 64-bit number, which gives a result of 0x7FFFFFFF.
- R6: If the shifted value does not fit in signed 32 bits, control bit 23 is set. With `satEn` the result is then 0x7FFFFFFF for positive values and 0x80000000 for negative ones; without it, the result is the low 32 bits. A value that fits leaves bit 23 as it came in.
- R7: Position mode (`fieldMode`=1) takes pos from control bits 5:0 and size from `amount`. It returns accumulator bits pos down to pos-size, right-aligned and zero-extended.
- R8: The extract is valid when pos >= size. A valid extract clears control bit 14. An invalid one returns 0, sets bit 14 and leaves bits 5:0 unchanged.
- R9: With `decEn` set, a valid position extract writes pos-size-1 into control bits 5:0, or 63 when pos equals size. Without `decEn`, bits 5:0 are unchanged.
- R10: Control bits not named above pass through unchanged. `roundEn` and `satEn` have no effect in position mode, and `decEn` has no effect in shift mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| fieldMode | input | 1 | 0 = shift mode, 1 = position mode |
| decEn | input | 1 | Step the position down after a valid extract |
| roundEn | input | 1 | Round before shifting |
| satEn | input | 1 | Clamp to signed 32 bits on overflow |
| amount | input | 5 | Shift amount or field size minus one |
| accIn | input | 64 | Accumulator value |
| ctlIn | input | 32 | Current control word |
| respValid | output | 1 | Response strobe, one cycle after a request |
| result | output | 32 | Extracted result |
| ctlOut | output | 32 | Updated control word |

## Verification
A wrong rounding carry or overflow decision shows at the ports on the response cycle right after the request. It appears as a result that is off by one, or as a wrong clamp value together with a missing or spurious bit 23. A wrong position computation shows in the same cycle, in the extracted field and in control bits 5:0 and 14. It would also corrupt every later extract that reuses the returned control word. The vectors cover both ends of the position range, the pos-equals-size wrap to 63, both clamp directions and the rounding overflow, each with its expected values worked out by hand.

// File: rtl/accx_pkg.sv
package accx_pkg;

  // Strobes sent by the control decoder to the datapath.
  typedef struct packed {
    logic load;     // capture a new response this cycle
    logic doField;  // position mode selected
    logic doRound;  // rounding active (shift mode, nonzero amount)
    logic doSat;    // saturation active (shift mode only)
    logic doDec;    // position step-down requested (position mode only)
  } accxStrobes_t;

endpackage

// File: rtl/accx_ctrl.sv
module accx_ctrl
  import accx_pkg::*;
#(
  parameter int AMT_W = 5
) (
  input  logic             reqValid,
  input  logic             fieldMode,
  input  logic             decEn,
  input  logic             roundEn,
  input  logic             satEn,
  input  logic [AMT_W-1:0] amount,
  output accxStrobes_t     strobes
);

  logic amountNonZero;

  assign amountNonZero = |amount;

  // Mode-specific enables are masked here so the datapath never sees an
  // option that does not belong to the selected mode.
  always_comb begin
    strobes         = '0;
    strobes.load    = reqValid;
    strobes.doField = fieldMode;
    strobes.doRound = roundEn & ~fieldMode & amountNonZero;
    strobes.doSat   = satEn & ~fieldMode;
    strobes.doDec   = decEn & fieldMode;
  end

endmodule

// File: rtl/accx_shr.sv
module accx_shr #(
  parameter int ACC_W = 64,
  parameter int RES_W = 32,
  parameter int AMT_W = 5
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [AMT_W-1:0] amount,
  input  logic             doRound,
  input  logic             doSat,
  output logic [RES_W-1:0] res,
  output logic             ovf
);

  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};

  logic [ACC_W-1:0]        halfLsb;
  logic [ACC_W-1:0]        roundSum;
  logic                    roundOvf;
  logic [ACC_W-1:0]        preShift;
  logic signed [ACC_W-1:0] shifted;
  logic [ACC_W-RES_W:0]    upperBits;
  logic                    fits;
  logic [RES_W-1:0]        clampVal;

  // Half of the weight of the lowest kept bit; zero when amount is zero.
  assign halfLsb  = (ACC_W'(1) << amount) >> 1;
  assign roundSum = acc + halfLsb;

  // Adding a positive constant can only wrap a non-negative value.
  assign roundOvf = doRound & ~acc[ACC_W-1] & roundSum[ACC_W-1];

  always_comb begin
    if (!doRound)              preShift = acc;
    else if (roundOvf & doSat) preShift = ACC_MAX;
    else                       preShift = roundSum;
  end

  assign shifted = $signed(preShift) >>> amount;

  // The value fits in RES_W signed bits when every bit from the result's
  // sign bit up to the top agrees.
  assign upperBits = shifted[ACC_W-1:RES_W-1];
  assign fits      = (&upperBits) | ~(|upperBits);
  assign ovf       = roundOvf | ~fits;

  assign clampVal = {shifted[ACC_W-1], {(RES_W-1){~shifted[ACC_W-1]}}};
  assign res      = (ovf & doSat) ? clampVal : shifted[RES_W-1:0];

endmodule

// File: rtl/accx_fld.sv
module accx_fld #(
  parameter int ACC_W = 64,
  parameter int RES_W = 32,
  parameter int AMT_W = 5,
  parameter int POS_W = 6
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [POS_W-1:0] pos,
  input  logic [AMT_W-1:0] size,
  output logic [RES_W-1:0] res,
  output logic             valid,
  output logic [POS_W-1:0] nextPos
);

  logic [POS_W-1:0] sizeWide;
  logic [POS_W-1:0] lowBit;
  logic [RES_W-1:0] fieldBits;

  assign sizeWide = POS_W'(size);
  assign valid    = pos >= sizeWide;
  assign lowBit   = pos - sizeWide;

  // Modulo-2^POS_W arithmetic turns a result of -1 into the top position.
  assign nextPos  = pos - sizeWide - POS_W'(1);

  // One selector per result bit; the index wraps inside the accumulator,
  // and bits above the field size are forced to zero.
  for (genvar k = 0; k < RES_W; k++) begin : g_bit
    logic [POS_W-1:0] srcIdx;
    assign srcIdx       = lowBit + POS_W'(k);
    assign fieldBits[k] = (AMT_W'(k) <= size) & acc[srcIdx];
  end

  assign res = valid ? fieldBits : '0;

endmodule

// File: rtl/accx_dp.sv
module accx_dp
  import accx_pkg::*;
#(
  parameter int ACC_W    = 64,
  parameter int RES_W    = 32,
  parameter int CTL_W    = 32,
  parameter int AMT_W    = 5,
  parameter int POS_W    = 6,
  parameter int OVF_BIT  = 23,
  parameter int FAIL_BIT = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  accxStrobes_t     strobes,
  input  logic [AMT_W-1:0] amount,
  input  logic [ACC_W-1:0] accIn,
  input  logic [CTL_W-1:0] ctlIn,
  output logic             respValid,
  output logic [RES_W-1:0] result,
  output logic [CTL_W-1:0] ctlOut
);

  logic [RES_W-1:0] shrRes;
  logic             shrOvf;
  logic [RES_W-1:0] fldRes;
  logic             fldValid;
  logic [POS_W-1:0] fldNextPos;
  logic [RES_W-1:0] nextRes;
  logic [CTL_W-1:0] nextCtl;

  accx_shr #(
    .ACC_W (ACC_W),
    .RES_W (RES_W),
    .AMT_W (AMT_W)
  ) i_shr (
    .acc     (accIn),
    .amount  (amount),
    .doRound (strobes.doRound),
    .doSat   (strobes.doSat),
    .res     (shrRes),
    .ovf     (shrOvf)
  );

  accx_fld #(
    .ACC_W (ACC_W),
    .RES_W (RES_W),
    .AMT_W (AMT_W),
    .POS_W (POS_W)
  ) i_fld (
    .acc     (accIn),
    .pos     (ctlIn[POS_W-1:0]),
    .size    (amount),
    .res     (fldRes),
    .valid   (fldValid),
    .nextPos (fldNextPos)
  );

  // Merge the mode's flag updates into the incoming control word.
  always_comb begin
    nextCtl = ctlIn;
    if (strobes.doField) begin
      if (fldValid) begin
        nextCtl[FAIL_BIT] = 1'b0;
        if (strobes.doDec) nextCtl[POS_W-1:0] = fldNextPos;
      end else begin
        nextCtl[FAIL_BIT] = 1'b1;
      end
    end else if (shrOvf) begin
      nextCtl[OVF_BIT] = 1'b1;
    end
  end

  assign nextRes = strobes.doField ? fldRes : shrRes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      result    <= '0;
      ctlOut    <= '0;
    end else begin
      respValid <= strobes.load;
      if (strobes.load) begin
        result <= nextRes;
        ctlOut <= nextCtl;
      end
    end
  end

endmodule

// File: rtl/acc_extract_unit.sv
module acc_extract_unit
  import accx_pkg::*;
#(
  parameter int ACC_W    = 64,
  parameter int RES_W    = 32,
  parameter int CTL_W    = 32,
  parameter int OVF_BIT  = 23,
  parameter int FAIL_BIT = 14,
  localparam int AMT_W   = $clog2(RES_W),
  localparam int POS_W   = $clog2(ACC_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             fieldMode,
  input  logic             decEn,
  input  logic             roundEn,
  input  logic             satEn,
  input  logic [AMT_W-1:0] amount,
  input  logic [ACC_W-1:0] accIn,
  input  logic [CTL_W-1:0] ctlIn,
  output logic             respValid,
  output logic [RES_W-1:0] result,
  output logic [CTL_W-1:0] ctlOut
);

  accxStrobes_t strobes;

  accx_ctrl #(
    .AMT_W (AMT_W)
  ) i_ctrl (
    .reqValid  (reqValid),
    .fieldMode (fieldMode),
    .decEn     (decEn),
    .roundEn   (roundEn),
    .satEn     (satEn),
    .amount    (amount),
    .strobes   (strobes)
  );

  accx_dp #(
    .ACC_W    (ACC_W),
    .RES_W    (RES_W),
    .CTL_W    (CTL_W),
    .AMT_W    (AMT_W),
    .POS_W    (POS_W),
    .OVF_BIT  (OVF_BIT),
    .FAIL_BIT (FAIL_BIT)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .amount    (amount),
    .accIn     (accIn),
    .ctlIn     (ctlIn),
    .respValid (respValid),
    .result    (result),
    .ctlOut    (ctlOut)
  );

endmodule

// File: rtl/accx_chk.sv
module accx_chk #(
  parameter int RES_W    = 32,
  parameter int CTL_W    = 32,
  parameter int AMT_W    = 5,
  parameter int POS_W    = 6,
  parameter int OVF_BIT  = 23,
  parameter int FAIL_BIT = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             fieldMode,
  input logic             decEn,
  input logic             satEn,
  input logic [AMT_W-1:0] amount,
  input logic [CTL_W-1:0] ctlIn,
  input logic             respValid,
  input logic [RES_W-1:0] result,
  input logic [CTL_W-1:0] ctlOut
);

  localparam logic [RES_W-1:0] RES_MAX = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] RES_MIN = {1'b1, {(RES_W-1){1'b0}}};

  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid && $stable(result) && $stable(ctlOut)); // R2

  AST_FIELD_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && fieldMode && (ctlIn[POS_W-1:0] < POS_W'(amount))
      |=> (result == '0) && ctlOut[FAIL_BIT]); // R8

  AST_NO_DEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && fieldMode && !decEn
      |=> ctlOut[POS_W-1:0] == $past(ctlIn[POS_W-1:0])); // R9

  AST_SHIFT_KEEPS_POS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !fieldMode
      |=> (ctlOut[POS_W-1:0] == $past(ctlIn[POS_W-1:0]))
          && (ctlOut[FAIL_BIT] == $past(ctlIn[FAIL_BIT]))); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && ctlIn[OVF_BIT] |=> ctlOut[OVF_BIT]); // R6

  AST_SAT_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !fieldMode && satEn && !ctlIn[OVF_BIT]
      |=> !ctlOut[OVF_BIT] || (result == RES_MAX) || (result == RES_MIN)); // R6

endmodule

bind acc_extract_unit accx_chk #(
  .RES_W    (RES_W),
  .CTL_W    (CTL_W),
  .AMT_W    (AMT_W),
  .POS_W    (POS_W),
  .OVF_BIT  (OVF_BIT),
  .FAIL_BIT (FAIL_BIT)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .fieldMode (fieldMode),
  .decEn     (decEn),
  .satEn     (satEn),
  .amount    (amount),
  .ctlIn     (ctlIn),
  .respValid (respValid),
  .result    (result),
  .ctlOut    (ctlOut)
);

// File: tb/test_acc_extract_unit.sv
module test_acc_extract_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic        fm;
    logic        dec;
    logic        rnd;
    logic        sat;
    logic [4:0]  amt;
    logic [63:0] acc;
    logic [31:0] ctl;
    logic [31:0] expRes;
    logic [31:0] expCtl;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 20;

  localparam vec_t VECS [NVEC] = '{
    // fm dec rnd sat amt  acc                    ctl            expRes         expCtl         req
    '{1'b0,1'b0,1'b0,1'b0,5'd0,  64'h0000_0000_1234_5678, 32'h0000_0000, 32'h1234_5678, 32'h0000_0000, 8'd3},  // R3 pass-through
    '{1'b0,1'b0,1'b0,1'b0,5'd4,  64'hFFFF_FFFF_FFFF_FF00, 32'hA500_0000, 32'hFFFF_FFF0, 32'hA500_0000, 8'd3},  // R3 negative shift
    '{1'b0,1'b0,1'b1,1'b0,5'd4,  64'h0000_0000_0000_0018, 32'h0000_0000, 32'h0000_0002, 32'h0000_0000, 8'd4},  // R4 round up
    '{1'b0,1'b0,1'b1,1'b0,5'd4,  64'h0000_0000_0000_0017, 32'h0000_0000, 32'h0000_0001, 32'h0000_0000, 8'd4},  // R4 round down
    '{1'b0,1'b0,1'b1,1'b0,5'd1,  64'hFFFF_FFFF_FFFF_FFFD, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 8'd4},  // R4 negative round
    '{1'b0,1'b0,1'b1,1'b0,5'd0,  64'h0000_0000_0000_0017, 32'h0000_0000, 32'h0000_0017, 32'h0000_0000, 8'd4},  // R4 amount zero
    '{1'b0,1'b0,1'b0,1'b1,5'd0,  64'h0000_0000_8000_0000, 32'h0000_0000, 32'h7FFF_FFFF, 32'h0080_0000, 8'd6},  // R6 clamp high
    '{1'b0,1'b0,1'b0,1'b0,5'd0,  64'h0000_0001_2345_6789, 32'h0000_0000, 32'h2345_6789, 32'h0080_0000, 8'd6},  // R6 no clamp
    '{1'b0,1'b0,1'b0,1'b1,5'd8,  64'h8000_0000_0000_0000, 32'h0000_0000, 32'h8000_0000, 32'h0080_0000, 8'd6},  // R6 clamp low
    '{1'b0,1'b0,1'b0,1'b0,5'd0,  64'h0000_0000_0000_0005, 32'h0080_0000, 32'h0000_0005, 32'h0080_0000, 8'd6},  // R6 flag kept
    '{1'b0,1'b0,1'b1,1'b1,5'd4,  64'h7FFF_FFFF_FFFF_FFFF, 32'h0000_0000, 32'h7FFF_FFFF, 32'h0080_0000, 8'd5},  // R5 saturated
    '{1'b0,1'b0,1'b1,1'b0,5'd4,  64'h7FFF_FFFF_FFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0080_0000, 8'd5},  // R5 wrapped
    '{1'b1,1'b0,1'b0,1'b0,5'd7,  64'h0000_0000_0000_AB00, 32'h0000_400F, 32'h0000_00AB, 32'h0000_000F, 8'd7},  // R7 mid field
    '{1'b1,1'b1,1'b0,1'b0,5'd7,  64'h0000_0000_0000_AB00, 32'h0000_000F, 32'h0000_00AB, 32'h0000_0007, 8'd9},  // R9 step down
    '{1'b1,1'b1,1'b0,1'b0,5'd7,  64'h0000_0000_0000_005A, 32'h0000_0007, 32'h0000_005A, 32'h0000_003F, 8'd9},  // R9 wrap to 63
    '{1'b1,1'b1,1'b0,1'b0,5'd4,  64'hFFFF_FFFF_FFFF_FFFF, 32'h1234_0003, 32'h0000_0000, 32'h1234_4003, 8'd8},  // R8 invalid
    '{1'b1,1'b0,1'b1,1'b1,5'd31, 64'hDEAD_BEEF_0000_0000, 32'h0080_003F, 32'hDEAD_BEEF, 32'h0080_003F, 8'd10}, // R10 opts ignored
    '{1'b0,1'b1,1'b0,1'b0,5'd0,  64'h0000_0000_0000_0007, 32'h0000_002A, 32'h0000_0007, 32'h0000_002A, 8'd10}, // R10 dec ignored
    '{1'b1,1'b1,1'b0,1'b0,5'd0,  64'h0000_0000_0000_0001, 32'h0000_0000, 32'h0000_0001, 32'h0000_003F, 8'd9},  // R9 size zero at bit 0
    '{1'b0,1'b0,1'b0,1'b0,5'd2,  64'h0000_0000_0000_0040, 32'h0000_4011, 32'h0000_0010, 32'h0000_4011, 8'd10}  // R10 bit 14 kept
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        fieldMode;
  logic        decEn;
  logic        roundEn;
  logic        satEn;
  logic [4:0]  amount;
  logic [63:0] accIn;
  logic [31:0] ctlIn;
  logic        respValid;
  logic [31:0] result;
  logic [31:0] ctlOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_extract_unit i_acc_extract_unit (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .fieldMode (fieldMode),
    .decEn     (decEn),
    .roundEn   (roundEn),
    .satEn     (satEn),
    .amount    (amount),
    .accIn     (accIn),
    .ctlIn     (ctlIn),
    .respValid (respValid),
    .result    (result),
    .ctlOut    (ctlOut)
  );

  task automatic check(input int req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  initial begin
    logic [31:0] lastRes;
    logic [31:0] lastCtl;
    rstN = 1'b0; reqValid = 1'b0; fieldMode = 1'b0; decEn = 1'b0;
    roundEn = 1'b0; satEn = 1'b0; amount = '0; accIn = '0; ctlIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: state after reset
    check(1, "respValid after reset", 64'(respValid), 64'd0);
    check(1, "result after reset", 64'(result), 64'd0);
    check(1, "ctlOut after reset", 64'(ctlOut), 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      reqValid  = 1'b1;
      fieldMode = VECS[i].fm;
      decEn     = VECS[i].dec;
      roundEn   = VECS[i].rnd;
      satEn     = VECS[i].sat;
      amount    = VECS[i].amt;
      accIn     = VECS[i].acc;
      ctlIn     = VECS[i].ctl;
      @(negedge clk);
      reqValid = 1'b0;
      check(2, $sformatf("vec %0d respValid", i), 64'(respValid), 64'd1);
      check(int'(VECS[i].req), $sformatf("vec %0d result", i), 64'(result), 64'(VECS[i].expRes));
      check(int'(VECS[i].req), $sformatf("vec %0d ctlOut", i), 64'(ctlOut), 64'(VECS[i].expCtl));
    end

    // R2: idle cycles keep the last response and drop the strobe
    lastRes = result;
    lastCtl = ctlOut;
    accIn   = 64'hFFFF_0000_FFFF_0000;
    ctlIn   = 32'h0000_0005;
    @(negedge clk);
    check(2, "idle respValid", 64'(respValid), 64'd0);
    check(2, "idle result hold", 64'(result), 64'(lastRes));
    check(2, "idle ctlOut hold", 64'(ctlOut), 64'(lastCtl));

    // R1: reset in mid-run clears the response
    rstN = 1'b0;
    @(negedge clk);
    check(1, "result during reset", 64'(result), 64'd0);
    check(1, "ctlOut during reset", 64'(ctlOut), 64'd0);
    check(1, "respValid during reset", 64'(respValid), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R8: size above position from a fresh state, no decrement applied
    reqValid = 1'b1; fieldMode = 1'b1; decEn = 1'b1; roundEn = 1'b0; satEn = 1'b0;
    amount = 5'd31; accIn = 64'hFFFF_FFFF_FFFF_FFFF; ctlIn = 32'h0000_001E;
    @(negedge clk);
    reqValid = 1'b0;
    check(8, "size 31 at pos 30 result", 64'(result), 64'd0);
    check(8, "size 31 at pos 30 ctlOut", 64'(ctlOut), 64'h0000_401E);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule